// File: doc/BRIEF.md
# Long-Press Reset Pulse Timer

This block turns a sustained press of an active-low push button into a reset pulse of fixed width. The button level passes through a synchronizer. A press that lasts for the configured hold time drives the reset output low. The output then stays low for a fixed recovery width. Releasing the button during that window does not shorten it, and holding the button past it does not stretch it. After the pulse, the timer waits for the button to be released before it accepts a new press. A continuous hold therefore yields exactly one pulse.

A mode input selects between normal operation and a test mode. In test mode the hold delay is removed and the pulse starts as soon as the press is seen. The mode is captured out of power-on reset. After that it only follows the input while the timer is idle and the button is released, so a change made during a press has no effect on that press. Durations are parameters in clock cycles. All pins are plain level signals; nothing streams through the block, so it has no valid/ready handshake.

Top module: `longpress_reset_timer`

## Requirements
- R1: While power-on reset is active, and afterwards until a qualifying press, `rst_out_n` is 1 and `rst_drive` is 0. The captured mode is normal after reset.
- R2: A press that ends before `HOLD_CYC` consecutive low samples of the synchronized button leaves the output high. This includes a press of exactly `HOLD_CYC-1` samples. Counting restarts from zero on the next press.
- R3: In normal mode, the output goes low in the cycle after the `HOLD_CYC`-th consecutive low synchronized sample. A button driven low just after clock edge t gives a first low output after edge t+`HOLD_CYC`+2.
- R4: Once low, the output stays low for exactly `PULSE_CYC` cycles, whatever the button does during them.
- R5: When the pulse ends, the output returns high even if the button is still held low.
- R6: After a pulse, no new pulse can start until the synchronized button has been seen high. A new press after release is timed from zero.
- R7: The mode register samples `test_sel` whenever the timer is idle and the synchronized button is high, including the first cycles after reset. 1 selects test mode and 0 selects normal mode.
- R8: In test mode, the first low synchronized sample starts the pulse, so the first low output follows edge t+3. The pulse still lasts `PULSE_CYC` cycles and follows the R6 re-arm rule.
- R9: A change on `test_sel` while a press is in progress is ignored. Only a sample taken in idle with the button released alters the mode used by the next press.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| btn_n | input | 1 | Push button, low = pressed |
| test_sel | input | 1 | Mode select: 1 = zero-delay test mode, 0 = normal |
| rst_out_n | output | 1 | Reset output level, low = reset asserted |
| rst_drive | output | 1 | Open-drain pull-down enable, 1 = pull the line low |

## Verification
Every state error in this block shows up on the reset output within one press. A hold count that is off by one moves the falling edge by a cycle, which shows up at the R3 boundary press of `HOLD_CYC-1` samples and at the measured latency. A pulse counter or exit decision that is wrong changes the measured width, or leaves the output low after release, within `PULSE_CYC` cycles. A missing wait-for-release state gives a second pulse during a long hold. A mode register that loads at the wrong time is exposed by a one-cycle release inside a press, which in test mode would produce a pulse three edges later.

// File: rtl/lpr_pkg.sv
package lpr_pkg;

  typedef enum logic [1:0] {
    LPR_IDLE  = 2'd0,
    LPR_COUNT = 2'd1,
    LPR_PULSE = 2'd2,
    LPR_WAIT  = 2'd3
  } lpr_state_e;

endpackage

// File: rtl/lpr_sync.sv
// Multi-stage level synchronizer; the last stage feeds the control logic.
module lpr_sync #(
  parameter int  STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);

  logic [STAGES-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= RESET_VAL;
          else        chain_q[0] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= RESET_VAL;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign d_out = chain_q[STAGES-1];

endmodule

// File: rtl/lpr_mode_latch.sv
// Holds the operating mode; loads only when the controller allows it.
module lpr_mode_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic sel,
  output logic mode_test
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mode_test <= 1'b0;
    else if (load) mode_test <= sel;
  end

endmodule

// File: rtl/lpr_counter.sv
// Saturating up-counter: start loads 1, run advances until TARGET is reached.
module lpr_counter #(
  parameter int unsigned TARGET = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic done
);

  localparam int unsigned W = (TARGET < 2) ? 1 : $clog2(TARGET + 1);
  localparam logic [W-1:0] TGT = W'(TARGET);

  logic [W-1:0] cnt_q;

  assign done = (cnt_q == TGT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (start)         cnt_q <= W'(1);
    else if (run && !done)  cnt_q <= cnt_q + W'(1);
  end

endmodule

// File: rtl/lpr_fsm.sv
// Controller: idle -> count -> pulse -> (wait for release) -> idle.
module lpr_fsm
  import lpr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       btn_s,       // synchronized button, 1 = released
  input  logic       mode_test,
  input  logic       hold_done,
  input  logic       pulse_done,
  output logic       hold_start,
  output logic       hold_run,
  output logic       pulse_start,
  output logic       pulse_run,
  output logic       mode_load,
  output logic       drive_q,
  output lpr_state_e state_q
);

  lpr_state_e state_d;

  always_comb begin
    state_d     = state_q;
    hold_start  = 1'b0;
    pulse_start = 1'b0;
    mode_load   = 1'b0;
    unique case (state_q)
      LPR_IDLE: begin
        if (btn_s) begin
          mode_load = 1'b1;
        end else if (mode_test) begin
          state_d     = LPR_PULSE;
          pulse_start = 1'b1;
        end else begin
          state_d    = LPR_COUNT;
          hold_start = 1'b1;
        end
      end
      LPR_COUNT: begin
        if (btn_s) begin
          state_d = LPR_IDLE;
        end else if (hold_done) begin
          state_d     = LPR_PULSE;
          pulse_start = 1'b1;
        end
      end
      LPR_PULSE: begin
        if (pulse_done) state_d = btn_s ? LPR_IDLE : LPR_WAIT;
      end
      LPR_WAIT: begin
        if (btn_s) state_d = LPR_IDLE;
      end
      default: state_d = LPR_IDLE;
    endcase
  end

  assign hold_run  = (state_q == LPR_COUNT);
  assign pulse_run = (state_q == LPR_PULSE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LPR_IDLE;
      drive_q <= 1'b0;
    end else begin
      state_q <= state_d;
      drive_q <= (state_d == LPR_PULSE);
    end
  end

endmodule

// File: rtl/longpress_reset_timer.sv
// Long-press reset pulse timer. HOLD_CYC must be at least 2, PULSE_CYC at least 1.
module longpress_reset_timer
  import lpr_pkg::*;
#(
  parameter int unsigned HOLD_CYC    = 937_500_000, // 7.5 s at 125 MHz
  parameter int unsigned PULSE_CYC   = 50_000_000,  // 400 ms at 125 MHz
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_n,
  input  logic test_sel,
  output logic rst_out_n,
  output logic rst_drive
);

  // The count-state check fires on the HOLD_CYC-th low sample; the idle
  // cycle that entered counting supplies the first one.
  localparam int unsigned HOLD_TGT = HOLD_CYC - 1;

  logic       btn_s;
  logic       mode_test;
  logic       hold_start, hold_run, hold_done;
  logic       pulse_start, pulse_run, pulse_done;
  logic       mode_load;
  logic       drive_q;
  lpr_state_e state_q;

  lpr_sync #(
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(1'b1)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_in (btn_n),
    .d_out(btn_s)
  );

  lpr_mode_latch u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (mode_load),
    .sel      (test_sel),
    .mode_test(mode_test)
  );

  lpr_counter #(.TARGET(HOLD_TGT)) u_hold (
    .clk  (clk),
    .rst_n(rst_n),
    .start(hold_start),
    .run  (hold_run),
    .done (hold_done)
  );

  lpr_counter #(.TARGET(PULSE_CYC)) u_pulse (
    .clk  (clk),
    .rst_n(rst_n),
    .start(pulse_start),
    .run  (pulse_run),
    .done (pulse_done)
  );

  lpr_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .btn_s      (btn_s),
    .mode_test  (mode_test),
    .hold_done  (hold_done),
    .pulse_done (pulse_done),
    .hold_start (hold_start),
    .hold_run   (hold_run),
    .pulse_start(pulse_start),
    .pulse_run  (pulse_run),
    .mode_load  (mode_load),
    .drive_q    (drive_q),
    .state_q    (state_q)
  );

  assign rst_drive = drive_q;
  assign rst_out_n = ~drive_q;

endmodule

// File: rtl/lpr_checker.sv
module lpr_checker
  import lpr_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input lpr_state_e state,
  input logic       btn_s,
  input logic       mode_test,
  input logic       hold_done,
  input logic       pulse_done,
  input logic       rst_out_n
);

  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LPR_IDLE) |-> rst_out_n);

  assert_short_press_abort_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LPR_COUNT && btn_s) |=> (state == LPR_IDLE && rst_out_n));

  assert_hold_reached_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LPR_COUNT && !btn_s && hold_done) |=> !rst_out_n);

  assert_pulse_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LPR_PULSE && !pulse_done) |=> !rst_out_n);

  assert_pulse_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LPR_PULSE && pulse_done) |=> rst_out_n);

  assert_no_back_to_back_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out_n) |=> rst_out_n);

  assert_test_mode_direct_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LPR_IDLE && !btn_s && mode_test) |=> !rst_out_n);

  assert_mode_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !btn_s |=> $stable(mode_test));

endmodule

bind longpress_reset_timer lpr_checker u_lpr_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .state     (state_q),
  .btn_s     (btn_s),
  .mode_test (mode_test),
  .hold_done (hold_done),
  .pulse_done(pulse_done),
  .rst_out_n (rst_out_n)
);

// File: tb/test_longpress_reset_timer.sv
`timescale 1ns/1ps
module test_longpress_reset_timer;

  localparam int HOLD  = 20;
  localparam int PULSE = 12;

  logic clk = 1'b0;
  logic rst_n;
  logic btn_n;
  logic test_sel;
  logic rst_out_n;
  logic rst_drive;

  always #4 clk = ~clk; // 125 MHz

  longpress_reset_timer #(
    .HOLD_CYC   (HOLD),
    .PULSE_CYC  (PULSE),
    .SYNC_STAGES(2)
  ) i_longpress_reset_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .btn_n    (btn_n),
    .test_sel (test_sel),
    .rst_out_n(rst_out_n),
    .rst_drive(rst_drive)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: button delay line, hold run length, pulse time left.
  int cyc = 0;
  bit m_s1 = 1, m_s2 = 1;
  int m_held = 0, m_left = 0;
  bit m_wait = 0, m_mode = 0;

  always @(posedge clk) begin
    bit s;
    cyc++;
    if (!rst_n) begin
      m_s1 = 1; m_s2 = 1; m_held = 0; m_left = 0; m_wait = 0; m_mode = 0;
    end else begin
      s = m_s2;
      if (m_left > 0) begin
        m_left--;
        if (m_left == 0) m_wait = !s;
      end else if (m_wait) begin
        if (s) m_wait = 0;
      end else if (s) begin
        if (m_held == 0) m_mode = test_sel;
        m_held = 0;
      end else begin
        m_held++;
        if (m_held >= (m_mode ? 1 : HOLD)) begin
          m_left = PULSE;
          m_held = 0;
        end
      end
      m_s2 = m_s1;
      m_s1 = btn_n;
    end
  end

  // Every-cycle comparison plus pulse measurement.
  int pulses = 0, run = 0, last_w = 0, fall_cyc = 0, t0 = 0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      string tag;
      bit exp_hi;
      exp_hi = (m_left == 0);
      if (m_left > 0)      tag = m_mode ? "R8" : "R4";
      else if (m_wait)     tag = "R6";
      else if (m_held > 0) tag = "R3";
      else                 tag = "R1";
      check(rst_out_n === exp_hi && rst_drive === !exp_hi, tag,
            int'(rst_out_n), int'(exp_hi));
      if (!rst_out_n) begin
        if (run == 0) fall_cyc = cyc;
        run++;
      end else if (run > 0) begin
        pulses++;
        last_w = run;
        run = 0;
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hold_press(input int n);
    btn_n = 1'b0;
    t0 = cyc;
    repeat (n) @(negedge clk);
    btn_n = 1'b1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(3);
  endtask

  initial begin
    btn_n = 1'b1; test_sel = 1'b0; rst_n = 1'b0;
    idle(4);
    rst_n = 1'b1;
    @(negedge clk);
    check(rst_out_n === 1'b1 && rst_drive === 1'b0, "R1 after reset", int'(rst_out_n), 1);

    hold_press(10); idle(30);
    check(pulses == 0, "R2 short press", pulses, 0);

    hold_press(HOLD - 1); idle(30);
    check(pulses == 0, "R2 one sample short", pulses, 0);

    hold_press(HOLD); idle(40);
    check(pulses == 1, "R3 exact hold", pulses, 1);
    check(fall_cyc - t0 == HOLD + 2, "R3 latency", fall_cyc - t0, HOLD + 2);
    check(last_w == PULSE, "R4 width", last_w, PULSE);

    hold_press(HOLD + 3); idle(40);
    check(pulses == 2, "R4 release during pulse", pulses, 2);
    check(last_w == PULSE, "R4 width after early release", last_w, PULSE);

    btn_n = 1'b0;
    idle(HOLD + PULSE + 20);
    check(rst_out_n === 1'b1, "R5 high while held", int'(rst_out_n), 1);
    check(pulses == 3, "R6 single pulse on long hold", pulses, 3);
    btn_n = 1'b1; idle(10);
    check(pulses == 3, "R6 no retrigger", pulses, 3);

    hold_press(HOLD); idle(40);
    check(pulses == 4, "R6 re-armed after release", pulses, 4);

    // Mode flip mid-press with a one-cycle release: the old mode must persist.
    btn_n = 1'b0; idle(5);
    test_sel = 1'b1; idle(5);
    btn_n = 1'b1; @(negedge clk);
    btn_n = 1'b0; idle(8);
    btn_n = 1'b1; idle(30);
    check(pulses == 4, "R9 mode change during press ignored", pulses, 4);

    hold_press(1); idle(30);
    check(pulses == 5, "R8 test mode pulse", pulses, 5);
    check(fall_cyc - t0 == 3, "R8 latency", fall_cyc - t0, 3);
    check(last_w == PULSE, "R8 width", last_w, PULSE);

    btn_n = 1'b0; idle(40);
    check(rst_out_n === 1'b1, "R8 released while held", int'(rst_out_n), 1);
    btn_n = 1'b1; idle(10);
    check(pulses == 6, "R8 single pulse with re-arm", pulses, 6);

    do_reset();
    hold_press(1); idle(30);
    check(pulses == 7, "R7 test mode captured at power-up", pulses, 7);

    test_sel = 1'b0;
    do_reset();
    hold_press(1); idle(30);
    check(pulses == 7, "R7 normal mode captured at power-up", pulses, 7);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule